// File: doc/BRIEF.md
# Gray-code Sobol sequence generator

This block streams one-dimensional quasi-random numbers from a Sobol sequence. It keeps a running index and a current output word. Each time a number is taken, it finds the lowest clear bit of the index. It reads the direction vector stored for that bit position, XORs it into the current output and increments the index. Because consecutive indices differ in one bit of their Gray code, the output stream equals the XOR of the vectors picked out by the Gray code of each index.

The direction vectors are computed off-chip. While the generator is held idle, they are written into a small on-chip table through an address/data/write-enable port. Raising the enable input starts the stream. The numbers leave through a valid/ready handshake, so the consumer sets the pace. When the index has every bit set, there is no clear bit left to select a vector. The generator then raises a sticky done flag and does not wrap around. A parameter can drop the leading zero value of the sequence.

Top module: `sobol_gen`

## Requirements
- R1: After reset, with enable low, out_valid and done are low. The first value presented once enable rises is 0 when SKIP_FIRST is 0.
- R2: The value presented for index i equals the XOR of table entries j over every bit j set in i ^ (i >> 1). Table entry j is the one written at address j.
- R3: While out_valid is high and out_ready is low, out_data and out_valid hold and the index does not advance.
- R4: Each accepted number (out_valid and out_ready high together) changes the output by exactly the table entry whose address is the position of the lowest 0 bit of the accepted index.
- R5: Accepting the number whose index has all IDX_W bits set raises done. From then on done stays high, out_valid stays low and out_data holds until reset.
- R6: A table write (dv_we high) lands only while en is low. A write attempted while en is high leaves the table unchanged.
- R7: With en low, out_valid is low and neither the index nor the output moves. Raising en again resumes at the same value.
- R8: With SKIP_FIRST set to 1, the value 0 is never presented. The first value presented is table entry 0, followed by the values for indices 1 up to all ones.
- R9: A synchronous reset returns the index and the output to zero and clears done, so the sequence restarts from its first value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low pauses generation and opens the table for writes |
| dv_we | input | 1 | Table write enable |
| dv_addr | input | AW | Table entry address, i.e. the bit position the vector serves |
| dv_data | input | OUT_W | Direction vector to store |
| out_valid | output | 1 | A number is offered on out_data |
| out_ready | input | 1 | Consumer accepts the offered number |
| out_data | output | OUT_W | Current sequence value |
| done | output | 1 | Sticky flag: the index space is used up |

## Verification
The in-line properties watch the handshake on every cycle. They check that a stalled number holds, that the index steps by exactly one per accepted number, and that the lowest-zero detector only points at a clear bit. They also check that done is sticky and silences out_valid, that a low enable silences the stream, and that the skip option never shows index zero. Whether the values themselves are correct depends on the contents of the table. Only the bench's scenarios can show that: a full sweep of a 4-bit index with two different vector sets, a write attempted during generation, the skip variant, and a restart after reset.

// File: rtl/sobol_pkg.sv
package sobol_pkg;

    // Generator phase: pending leading-zero skip, streaming, or exhausted
    typedef enum logic [1:0] {
        PH_SKIP = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

endpackage

// File: rtl/sobol_lsz_enc.sv
module sobol_lsz_enc #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic [W-1:0]  idx,
    output logic [AW-1:0] pos,
    output logic          found
);

    // Scan from the top so the lowest clear bit wins
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!idx[i]) begin
                pos   = AW'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sobol_dv_array.sv
module sobol_dv_array #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = (int'(rd_addr) < DEPTH) ? mem_q[rd_addr] : '0;

endmodule

// File: rtl/sobol_gen.sv
module sobol_gen
    import sobol_pkg::*;
#(
    parameter int IDX_W      = 32,
    parameter int OUT_W      = 16,
    parameter bit SKIP_FIRST = 1'b0,
    localparam int AW = (IDX_W > 1) ? $clog2(IDX_W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             dv_we,
    input  logic [AW-1:0]    dv_addr,
    input  logic [OUT_W-1:0] dv_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_data,
    output logic             done
);

    localparam phase_e PH_START = SKIP_FIRST ? PH_SKIP : PH_RUN;

    typedef struct packed {
        phase_e           ph;
        logic [IDX_W-1:0] idx;
        logic [OUT_W-1:0] r;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [AW-1:0]    lsz_pos;
    logic             lsz_found;
    logic [OUT_W-1:0] dv_sel;
    logic             take;

    sobol_lsz_enc #(.W(IDX_W), .AW(AW)) u_lsz (
        .idx   (st_q.idx),
        .pos   (lsz_pos),
        .found (lsz_found)
    );

    // Table accepts writes only while generation is held off
    sobol_dv_array #(.DEPTH(IDX_W), .DW(OUT_W), .AW(AW)) u_dva (
        .clk     (clk),
        .wr_en   (dv_we && !en),
        .wr_addr (dv_addr),
        .wr_data (dv_data),
        .rd_addr (lsz_pos),
        .rd_data (dv_sel)
    );

    always_comb begin
        st_d      = st_q;
        out_valid = en && (st_q.ph == PH_RUN);
        take      = 1'b0;
        unique case (st_q.ph)
            PH_SKIP: begin
                if (en) begin
                    take    = 1'b1;
                    st_d.ph = PH_RUN;
                end
            end
            PH_RUN: begin
                if (en && out_ready) begin
                    if (lsz_found) begin
                        take = 1'b1;
                    end else begin
                        st_d.ph = PH_DONE;
                    end
                end
            end
            default: begin
                st_d.ph = PH_DONE;
            end
        endcase
        if (take) begin
            st_d.idx = st_q.idx + IDX_W'(1);
            st_d.r   = st_q.r ^ dv_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ph  <= PH_START;
            st_q.idx <= '0;
            st_q.r   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data = st_q.r;
    assign done     = (st_q.ph == PH_DONE);

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> $stable(out_data) && $stable(st_q.idx)) // R3
        else $error("stalled number moved");

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && lsz_found |=> st_q.idx == $past(st_q.idx) + IDX_W'(1)) // R2
        else $error("index did not step by one");

    AST_LSZ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        lsz_found |-> !st_q.idx[lsz_pos]) // R4
        else $error("selected position is not a clear bit");

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done |=> done && $stable(out_data)) // R5
        else $error("done released or output moved");

    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid) // R5
        else $error("valid while done");

    AST_PAUSE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !en |-> !out_valid) // R7
        else $error("valid while paused");

    generate
        if (SKIP_FIRST) begin : g_skip_chk
            AST_SKIP_ZERO: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> st_q.idx != '0) // R8
                else $error("index zero presented with skip on");
        end
    endgenerate

endmodule

// File: tb/sobol_gen_test.sv
module sobol_gen_test;

    localparam int NB = 4;
    localparam int AW = 2;
    localparam int N  = 1 << NB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0, en_s = 1'b0;
    logic          dv_we = 1'b0;
    logic [AW-1:0] dv_addr = '0;
    logic [15:0]   dv_data = '0;
    logic          out_ready = 1'b1;
    logic          out_valid, done, valid_s, done_s;
    logic [15:0]   out_data, data_s;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [15:0] vset [NB];

    always #10 clk = ~clk;

    sobol_gen #(.IDX_W(NB), .OUT_W(16), .SKIP_FIRST(1'b0)) uut (
        .clk(clk), .rst(rst), .en(en), .dv_we(dv_we), .dv_addr(dv_addr),
        .dv_data(dv_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done));

    sobol_gen #(.IDX_W(NB), .OUT_W(16), .SKIP_FIRST(1'b1)) uut_skip (
        .clk(clk), .rst(rst), .en(en_s), .dv_we(dv_we), .dv_addr(dv_addr),
        .dv_data(dv_data), .out_valid(valid_s), .out_ready(out_ready),
        .out_data(data_s), .done(done_s));

    function automatic logic [15:0] ref_val(int i);
        int g = i ^ (i >> 1);
        logic [15:0] x = '0;
        for (int j = 0; j < NB; j++) if (g[j]) x ^= vset[j];
        return x;
    endfunction

    function automatic int lowest_zero(int i);
        for (int j = 0; j < NB; j++) if (!i[j]) return j;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic load_vectors();
        for (int j = 0; j < NB; j++) begin
            dv_we = 1'b1; dv_addr = AW'(j); dv_data = vset[j];
            tick();
        end
        dv_we = 1'b0;
    endtask

    initial begin
        logic [15:0] prev;
        int k, ks;
        tick(); tick();
        rst = 1'b0;
        tick();
        chk(!out_valid && !done, "R1", {out_valid, done}, 0);

        // Set A: classic single-bit direction vectors
        for (int j = 0; j < NB; j++) vset[j] = 16'h8000 >> j;
        load_vectors();
        en = 1'b1;
        #1;
        prev = '0;
        for (int i = 0; i < N; i++) begin
            chk(out_valid && out_data == ref_val(i), (i == 0) ? "R1" : "R2", out_data, ref_val(i));
            if (i > 0) chk((out_data ^ prev) == vset[lowest_zero(i - 1)], "R4",
                           out_data ^ prev, vset[lowest_zero(i - 1)]);
            if (i == 13) chk(out_data == ref_val(13), "R6", out_data, ref_val(13));
            prev = out_data;
            if (i == 5) begin
                out_ready = 1'b0;
                repeat (3) begin
                    tick();
                    chk(out_valid && out_data == ref_val(5), "R3", out_data, ref_val(5));
                end
                out_ready = 1'b1;
            end
            if (i == 9) begin
                en = 1'b0;
                repeat (2) begin
                    tick();
                    chk(!out_valid, "R7", out_valid, 0);
                end
                en = 1'b1;
                #1;
                chk(out_valid && out_data == ref_val(9), "R7", out_data, ref_val(9));
            end
            if (i == 11) begin
                dv_we = 1'b1; dv_addr = '0; dv_data = ~vset[0];
            end
            tick();
            dv_we = 1'b0;
        end
        chk(done && !out_valid, "R5", {done, out_valid}, 2);
        repeat (3) begin
            tick();
            chk(done && !out_valid && out_data == ref_val(N - 1), "R5", out_data, ref_val(N - 1));
        end

        // Restart with set B, plain and skip instances side by side
        en = 1'b0;
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        chk(!done && out_data == 16'h0 && !out_valid, "R9", out_data, 0);
        for (int j = 0; j < NB; j++) vset[j] = 16'(j * 40503 + 12345) ^ 16'hA5C3;
        load_vectors();
        en = 1'b1; en_s = 1'b1;
        #1;
        chk(!valid_s, "R8", valid_s, 0);
        k = 0; ks = 1;
        for (int c = 0; c < N + 4; c++) begin
            if (k < N) begin
                chk(out_valid && out_data == ref_val(k), "R9", out_data, ref_val(k));
                k++;
            end
            if (valid_s) begin
                chk(ks < N && data_s == ref_val(ks), "R8", data_s, ref_val(ks));
                ks++;
            end
            tick();
        end
        chk(ks == N && done_s, "R8", ks, N);
        chk(done && !out_valid, "R5", done, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #2ms;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule